// File: doc/BRIEF.md
# Wavefront Fence Readiness Tracker

This block sits in a shader core beside the memory pipeline and decides when a memory fence issued by a wavefront may retire. For every wavefront it keeps two pieces of state: how many of its writes are still in flight to the shared cache, and the latest global expiry time returned with any of its write acknowledgments. A write that reaches the shared cache while other cores may still hold a copy comes back with the time by which all those copies have self-invalidated. A fence may retire only when the wavefront has no writes in flight and that latest expiry time lies strictly in the past of the shared system time.

Writes need not stall for invalidations and no invalidation acknowledgments travel anywhere. The fence is the only point where a wavefront waits, and it waits on locally held state plus the shared time input. Acknowledgments for writes to private lines return no expiry time and only retire the write.

Top module: `fence_tracker`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears every wavefront's in-flight count and stored expiry time to zero, so with a nonzero system time every bit of fence_ready_o is 1.
- R2: A write issue (wr_issue_valid_i with wavefront id wr_issue_wid_i) adds one to that wavefront's in-flight count from the next clock edge; while the count is nonzero the wavefront's fence_ready_o bit is 0. Other wavefronts are unaffected.
- R3: A write acknowledgment (wr_ack_valid_i, id wr_ack_wid_i) subtracts one from that wavefront's in-flight count at the next edge; the count reaches zero only after as many acknowledgments as issues, up to the maximum in-flight depth of 63.
- R4: An issue and an acknowledgment for the same wavefront in the same cycle leave its count unchanged; events for different wavefronts in one cycle act independently.
- R5: An acknowledgment with wr_ack_has_ts_i = 1 replaces the stored expiry time with the larger of the stored value and wr_ack_ts_i (32-bit, unsigned) at the same edge as the count decrement; a smaller value leaves the stored time as it was.
- R6: An acknowledgment with wr_ack_has_ts_i = 0 leaves the stored expiry time unchanged, whatever wr_ack_ts_i holds.
- R7: fence_ready_o[w] is 1 exactly when wavefront w has a zero in-flight count and its stored expiry time is strictly less than sys_time_i; it follows sys_time_i in the same cycle.
- R8: fence_grant_o is 1 in the cycle fence_valid_i is 1 and fence_ready_o[fence_wid_i] is 1, with no added latency; with fence_valid_i = 0 it is 0.
- R9: Ids of NUM_WAVES (48) and above on any input are ignored: they change no state and a fence request with such an id is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_time_i | input | 32 | Shared synchronized system time |
| wr_issue_valid_i | input | 1 | A write of one wavefront leaves the core |
| wr_issue_wid_i | input | 6 | Wavefront id of the issued write |
| wr_ack_valid_i | input | 1 | A write acknowledgment arrives |
| wr_ack_wid_i | input | 6 | Wavefront id of the acknowledged write |
| wr_ack_has_ts_i | input | 1 | Acknowledgment carries an expiry time |
| wr_ack_ts_i | input | 32 | Expiry time carried by the acknowledgment |
| fence_valid_i | input | 1 | A fence asks to retire |
| fence_wid_i | input | 6 | Wavefront id of the fence |
| fence_ready_o | output | 48 | Per-wavefront fence may retire |
| fence_grant_o | output | 1 | The requested fence retires this cycle |

## Verification
A count that drifts shows as a fence_ready_o bit that stays low after the matching acknowledgments, or rises one acknowledgment early, visible in the cycle after the offending event. A stored expiry time that is lowered, raised by a private acknowledgment or left unmerged shows only once sys_time_i sweeps past the true value, so the bench steps the time through the boundary, including equality, right after each merge. Wrong id decoding shows as a neighbouring or out-of-range wavefront's ready bit changing.

// File: rtl/fence_pkg.sv
package fence_pkg;
  localparam int unsigned NUM_WAVES_DEF    = 48;
  localparam int unsigned TS_W_DEF         = 32;
  localparam int unsigned MAX_INFLIGHT_DEF = 63;

  typedef enum logic [1:0] {
    ACK_NONE   = 2'd0,
    ACK_PRIV   = 2'd1,
    ACK_GLOBAL = 2'd2
  } ack_kind_e;

  function automatic ack_kind_e ack_kind(input logic valid, input logic has_ts);
    if (!valid)      return ACK_NONE;
    else if (has_ts) return ACK_GLOBAL;
    else             return ACK_PRIV;
  endfunction
endpackage

// File: rtl/fence_wid_dec.sv
module fence_wid_dec #(
  parameter int unsigned NUM_WAVES = 48,
  parameter int unsigned WID_W     = 6
) (
  input  logic                 valid_i,
  input  logic [WID_W-1:0]     wid_i,
  output logic [NUM_WAVES-1:0] hit_o
);
  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_dec
    assign hit_o[w] = valid_i && (wid_i == WID_W'(w));
  end
endmodule

// File: rtl/fence_pend_ctr.sv
module fence_pend_ctr #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (inc_i && !dec_i) cnt_q <= cnt_q + CNT_W'(1);
    else if (dec_i && !inc_i) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fence_ts_reg.sv
module fence_ts_reg #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [TS_W-1:0] ts_i,
  output logic [TS_W-1:0] ts_o
);
  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ts_q <= '0;
    else if (upd_i && ts_i > ts_q) ts_q <= ts_i;
  end

  assign ts_o = ts_q;
endmodule

// File: rtl/fence_tracker.sv
module fence_tracker
  import fence_pkg::*;
#(
  parameter int unsigned NUM_WAVES    = NUM_WAVES_DEF,
  parameter int unsigned TS_W         = TS_W_DEF,
  parameter int unsigned MAX_INFLIGHT = MAX_INFLIGHT_DEF,
  localparam int unsigned WID_W       = $clog2(NUM_WAVES),
  localparam int unsigned CNT_W       = $clog2(MAX_INFLIGHT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TS_W-1:0]      sys_time_i,
  input  logic                 wr_issue_valid_i,
  input  logic [WID_W-1:0]     wr_issue_wid_i,
  input  logic                 wr_ack_valid_i,
  input  logic [WID_W-1:0]     wr_ack_wid_i,
  input  logic                 wr_ack_has_ts_i,
  input  logic [TS_W-1:0]      wr_ack_ts_i,
  input  logic                 fence_valid_i,
  input  logic [WID_W-1:0]     fence_wid_i,
  output logic [NUM_WAVES-1:0] fence_ready_o,
  output logic                 fence_grant_o
);
  ack_kind_e ack_kind_s;
  logic [NUM_WAVES-1:0] issue_hit, ack_hit, merge_hit, fence_hit;
  logic [NUM_WAVES-1:0][CNT_W-1:0] pend_cnt;
  logic [NUM_WAVES-1:0][TS_W-1:0]  stored_ts;
  logic [NUM_WAVES-1:0] pend_zero;

  assign ack_kind_s = ack_kind(wr_ack_valid_i, wr_ack_has_ts_i);

  fence_wid_dec #(.NUM_WAVES(NUM_WAVES), .WID_W(WID_W)) u_dec_issue (
    .valid_i(wr_issue_valid_i), .wid_i(wr_issue_wid_i), .hit_o(issue_hit));
  fence_wid_dec #(.NUM_WAVES(NUM_WAVES), .WID_W(WID_W)) u_dec_ack (
    .valid_i(ack_kind_s != ACK_NONE), .wid_i(wr_ack_wid_i), .hit_o(ack_hit));
  fence_wid_dec #(.NUM_WAVES(NUM_WAVES), .WID_W(WID_W)) u_dec_merge (
    .valid_i(ack_kind_s == ACK_GLOBAL), .wid_i(wr_ack_wid_i), .hit_o(merge_hit));
  fence_wid_dec #(.NUM_WAVES(NUM_WAVES), .WID_W(WID_W)) u_dec_fence (
    .valid_i(fence_valid_i), .wid_i(fence_wid_i), .hit_o(fence_hit));

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
    fence_pend_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (issue_hit[w]),
      .dec_i (ack_hit[w]),
      .cnt_o (pend_cnt[w]),
      .zero_o(pend_zero[w])
    );
    fence_ts_reg #(.TS_W(TS_W)) u_ts (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .upd_i (merge_hit[w]),
      .ts_i  (wr_ack_ts_i),
      .ts_o  (stored_ts[w])
    );
    // expired only once the stored time is strictly behind system time
    assign fence_ready_o[w] = pend_zero[w] && (stored_ts[w] < sys_time_i);
  end

  assign fence_grant_o = |(fence_hit & fence_ready_o);
endmodule

// File: rtl/fence_tracker_chk.sv
module fence_tracker_chk #(
  parameter int unsigned NUM_WAVES    = 48,
  parameter int unsigned TS_W         = 32,
  parameter int unsigned MAX_INFLIGHT = 63,
  parameter int unsigned WID_W        = 6,
  parameter int unsigned CNT_W        = 6
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            wr_issue_valid_i,
  input logic [WID_W-1:0]                wr_issue_wid_i,
  input logic                            wr_ack_valid_i,
  input logic [WID_W-1:0]                wr_ack_wid_i,
  input logic                            wr_ack_has_ts_i,
  input logic                            fence_valid_i,
  input logic [WID_W-1:0]                fence_wid_i,
  input logic [NUM_WAVES-1:0]            fence_ready_o,
  input logic                            fence_grant_o,
  input logic [NUM_WAVES-1:0][CNT_W-1:0] pend_cnt,
  input logic [NUM_WAVES-1:0][TS_W-1:0]  stored_ts
);
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_grant_o |-> fence_valid_i && (int'(fence_wid_i) < NUM_WAVES)); // R8

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_chk
    logic iss_w, ack_w;
    assign iss_w = wr_issue_valid_i && (wr_issue_wid_i == WID_W'(w));
    assign ack_w = wr_ack_valid_i && (wr_ack_wid_i == WID_W'(w));

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss_w && !ack_w) |-> (pend_cnt[w] != CNT_W'(MAX_INFLIGHT))); // R2
    AST_ISSUE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss_w && !ack_w) |=> !fence_ready_o[w]); // R2
    AST_ACK_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_w && !iss_w) |=> (pend_cnt[w] == $past(pend_cnt[w]) - CNT_W'(1))); // R3
    AST_PAIR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_w && iss_w) |=> $stable(pend_cnt[w])); // R4
    AST_TS_MONOTONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (stored_ts[w] >= $past(stored_ts[w]))); // R5
    AST_PRIV_KEEPS_TS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_w && !wr_ack_has_ts_i) |=> $stable(stored_ts[w])); // R6
  end
endmodule

bind fence_tracker fence_tracker_chk #(
  .NUM_WAVES(NUM_WAVES), .TS_W(TS_W), .MAX_INFLIGHT(MAX_INFLIGHT),
  .WID_W(WID_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .wr_issue_valid_i(wr_issue_valid_i), .wr_issue_wid_i(wr_issue_wid_i),
  .wr_ack_valid_i(wr_ack_valid_i), .wr_ack_wid_i(wr_ack_wid_i),
  .wr_ack_has_ts_i(wr_ack_has_ts_i),
  .fence_valid_i(fence_valid_i), .fence_wid_i(fence_wid_i),
  .fence_ready_o(fence_ready_o), .fence_grant_o(fence_grant_o),
  .pend_cnt(pend_cnt), .stored_ts(stored_ts)
);

// File: tb/fence_tracker_tb_top.sv
module fence_tracker_tb_top;
  localparam int NW = 48;
  localparam int TW = 32;
  localparam int IW = 6;

  typedef struct packed {
    logic          iv;
    logic [IW-1:0] iw;
    logic          av;
    logic [IW-1:0] aw;
    logic          at;
    logic [TW-1:0] ats;
    logic          fv;
    logic [IW-1:0] fw;
    logic [TW-1:0] now;
    logic          eg;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 16;
  // grant is sampled before the edge that applies the vector's events
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 32'd0,    1'b1, 6'd0,  32'd5,  1'b1, 4'd1},
    '{1'b1, 6'd3,  1'b0, 6'd0,  1'b0, 32'd0,    1'b0, 6'd0,  32'd6,  1'b0, 4'd8},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 32'd0,    1'b1, 6'd3,  32'd7,  1'b0, 4'd2},
    '{1'b1, 6'd3,  1'b0, 6'd0,  1'b0, 32'd0,    1'b1, 6'd4,  32'd8,  1'b1, 4'd4},
    '{1'b0, 6'd0,  1'b1, 6'd3,  1'b1, 32'd20,   1'b1, 6'd3,  32'd9,  1'b0, 4'd2},
    '{1'b1, 6'd3,  1'b1, 6'd3,  1'b0, 32'd0,    1'b1, 6'd3,  32'd10, 1'b0, 4'd3},
    '{1'b0, 6'd0,  1'b1, 6'd3,  1'b1, 32'd15,   1'b1, 6'd3,  32'd11, 1'b0, 4'd4},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 32'd0,    1'b1, 6'd3,  32'd12, 1'b0, 4'd7},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 32'd0,    1'b1, 6'd3,  32'd20, 1'b0, 4'd5},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 32'd0,    1'b1, 6'd3,  32'd21, 1'b1, 4'd7},
    '{1'b1, 6'd47, 1'b0, 6'd0,  1'b0, 32'd0,    1'b1, 6'd47, 32'd22, 1'b1, 4'd8},
    '{1'b0, 6'd0,  1'b1, 6'd47, 1'b0, 32'd1000, 1'b1, 6'd47, 32'd23, 1'b0, 4'd3},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 32'd0,    1'b1, 6'd47, 32'd24, 1'b1, 4'd6},
    '{1'b1, 6'd48, 1'b1, 6'd63, 1'b1, 32'd500,  1'b1, 6'd48, 32'd25, 1'b0, 4'd9},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 32'd0,    1'b1, 6'd0,  32'd26, 1'b1, 4'd9},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 32'd0,    1'b0, 6'd3,  32'd27, 1'b0, 4'd8}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] sys_time = '0;
  logic          iss_v = 1'b0, ack_v = 1'b0, ack_t = 1'b0, fen_v = 1'b0;
  logic [IW-1:0] iss_w = '0, ack_w = '0, fen_w = '0;
  logic [TW-1:0] ack_ts = '0;
  logic [NW-1:0] ready;
  logic          grant;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fence_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sys_time_i(sys_time),
    .wr_issue_valid_i(iss_v), .wr_issue_wid_i(iss_w),
    .wr_ack_valid_i(ack_v), .wr_ack_wid_i(ack_w),
    .wr_ack_has_ts_i(ack_t), .wr_ack_ts_i(ack_ts),
    .fence_valid_i(fen_v), .fence_wid_i(fen_w),
    .fence_ready_o(ready), .fence_grant_o(grant)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    iss_v = 1'b0; ack_v = 1'b0; ack_t = 1'b0; fen_v = 1'b0; ack_ts = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    sys_time = 32'd1;
    #12;
    chk("R1", 64'(ready), 64'({NW{1'b1}}));
    rst_n = 1'b1;
    tick();

    foreach (VECS[i]) begin
      iss_v = VECS[i].iv; iss_w = VECS[i].iw;
      ack_v = VECS[i].av; ack_w = VECS[i].aw;
      ack_t = VECS[i].at; ack_ts = VECS[i].ats;
      fen_v = VECS[i].fv; fen_w = VECS[i].fw;
      sys_time = VECS[i].now;
      #3;
      chk($sformatf("R%0d", VECS[i].rq), 64'(grant), 64'(VECS[i].eg));
      tick();
    end
    idle();

    // R9: out-of-range events touched nobody; every wave idle and expired
    sys_time = 32'd30; #2;
    chk("R9", 64'(ready), 64'({NW{1'b1}}));

    // R3: fill wave 5 to full depth, drain one short, then drain last
    for (int k = 0; k < 63; k++) begin
      iss_v = 1'b1; iss_w = 6'd5; tick();
    end
    idle(); #2;
    chk("R3", 64'(ready), 64'({NW{1'b1}} & ~(48'd1 << 5)));
    for (int k = 0; k < 62; k++) begin
      ack_v = 1'b1; ack_w = 6'd5; tick();
    end
    idle(); #2;
    chk("R3", 64'(ready[5]), 64'd0);
    ack_v = 1'b1; ack_w = 6'd5; tick();
    idle(); #2;
    chk("R3", 64'(ready[5]), 64'd1);

    // R5: wave 10 merges 100, private ack then must not disturb it
    iss_v = 1'b1; iss_w = 6'd10; tick();
    iss_v = 1'b1; iss_w = 6'd10;
    ack_v = 1'b1; ack_w = 6'd10; ack_t = 1'b1; ack_ts = 32'd100; tick();
    idle();
    ack_v = 1'b1; ack_w = 6'd10; ack_t = 1'b0; ack_ts = 32'd5000; tick();
    idle();
    sys_time = 32'd100; #2;
    chk("R7", 64'(ready[10]), 64'd0);
    sys_time = 32'd101; #2;
    chk("R6", 64'(ready[10]), 64'd1);
    chk("R4", 64'(ready[9]), 64'd1);
    // R7: ready follows system time in the same cycle
    sys_time = 32'd50; #2;
    chk("R7", 64'(ready[10]), 64'd0);

    // R1: reset mid-run clears stored time and counts
    iss_v = 1'b1; iss_w = 6'd2; tick(); idle();
    rst_n = 1'b0; #2;
    chk("R1", 64'(ready), 64'({NW{1'b1}}));
    tick();
    rst_n = 1'b1; tick();
    fen_v = 1'b1; fen_w = 6'd10; #2;
    chk("R8", 64'(grant), 64'd1);
    fen_v = 1'b0; #2;
    chk("R8", 64'(grant), 64'd0);
    tick();
    finish_run();
  end
endmodule